// File: doc/BRIEF.md
# USB Pipe Response-PID Controller

This block keeps the response PID of one USB pipe and rewrites it in hardware when the transfer machinery reports certain events. Software writes the PID and the pipe configuration through a simple register write port. Packet engines report their results as one-cycle strobes: a short packet, the end of the transaction counter, a correctly received SETUP, a received STALL handshake, an oversize packet, or a control sequence error. Depending on host or function mode, on whether the pipe is a bulk pipe with short-NAK enabled, and on whether the pipe is the default control pipe, these strobes force the PID to NAK or to STALL.

In host mode the block gives a token-issue enable that is high only while the PID allows transfers. In function mode it gives the handshake to return. While the PID is in the transfer-enabled state, writes to the protected configuration fields are dropped. Only the PID itself and the control-complete bit stay writable.

Top module: `usb_pipe_pid_ctrl`

## Requirements
- R1: After reset the PID is 00 (NAK), every register reads zero, token_en_o is 0 and hs_sel_o is 00.
- R2: PID encoding is 00 = NAK, 01 = BUF, 10 or 11 = STALL. A write to address 0 loads wr_data_i[1:0] into the PID one cycle later. Only such a write moves the PID into BUF.
- R3: In host mode, ev_stall_hs_i forces the PID to 10 (STALL). In function mode it has no effect.
- R4: In either mode, ev_oversize_i forces the PID to 10.
- R5: When cfg bit 0 (bulk) and cfg bit 1 (short-NAK) are both set, ev_short_i or ev_trn_end_i forces the PID to 00. If either bit is clear, these strobes have no effect.
- R6: In function mode, with the DEF_CTRL parameter set, ev_setup_i forces the PID to 00. In host mode it has no effect.
- R7: In function mode, ev_seq_err_i forces the PID to 10. In host mode it has no effect.
- R8: A STALL-forcing event wins over a NAK-forcing event in the same cycle. Any forcing event wins over a same-cycle PID write.
- R9: While the PID is 01, these writes are ignored: writes to addresses 1 (cfg), 2 (buffer), 3 (max packet) and 4 (period), and writes to bits DATA_W-1:3 of address 0. The PID bits [1:0] and the control-complete bit [2] of address 0 are still written. Addresses 5 to 7 are never stored.
- R10: token_en_o is 1 exactly when host_mode_i is 1 and the PID is 01.
- R11: hs_sel_o is 00 (NAK) for PID 00, 01 (ACK/data) for PID 01, and 10 (STALL) for PID 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | 1 = host controller, 0 = function controller |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address (0 ctl, 1 cfg, 2 buf, 3 maxp, 4 period) |
| wr_data_i | input | DATA_W | Write data |
| ev_setup_i | input | 1 | SETUP token received correctly |
| ev_stall_hs_i | input | 1 | STALL handshake received for an issued token |
| ev_oversize_i | input | 1 | Received packet exceeds max packet size |
| ev_short_i | input | 1 | Short packet received |
| ev_trn_end_i | input | 1 | Transaction counter reached its end |
| ev_seq_err_i | input | 1 | Control transfer sequence error |
| pid_o | output | 2 | Current response PID |
| token_en_o | output | 1 | Host token-issue enable |
| hs_sel_o | output | 2 | Function handshake selection |
| ctl_o | output | DATA_W | Control register: misc[DATA_W-1:3], done[2], PID[1:0] |
| cfg_o | output | DATA_W | Pipe configuration (bit 0 bulk, bit 1 short-NAK) |
| buf_cfg_o | output | DATA_W | Buffer configuration |
| maxp_o | output | DATA_W | Max packet size field |
| period_o | output | DATA_W | Period field |

## Verification
The bench builds the block with DATA_W = 16, ADDR_W = 3 and DEF_CTRL = 1. With DEF_CTRL = 1 the SETUP-to-NAK rule of the default control pipe can be exercised. With a 3-bit address the unused addresses 5 to 7 can be exercised as well. The 16-bit registers give 13 protected control bits, so a write that is only partly locked can be seen at the ports. Random event mixes in both modes put same-cycle STALL, NAK and software-write collisions in reach alongside the directed cases.

// File: rtl/usb_pid_pkg.sv
package usb_pid_pkg;
  typedef enum logic [1:0] {
    PID_NAK   = 2'b00,
    PID_BUF   = 2'b01,
    PID_STALL = 2'b10,
    PID_STALX = 2'b11
  } pid_e;

  typedef enum logic [1:0] {
    HS_NAK   = 2'b00,
    HS_ACK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  localparam int unsigned REG_CTL  = 0;
  localparam int unsigned REG_CFG  = 1;
  localparam int unsigned NUM_CFG  = 4;   // cfg, buf, maxp, period
  localparam int unsigned CFG_BULK = 0;
  localparam int unsigned CFG_SNAK = 1;
  localparam int unsigned CTL_DONE = 2;
endpackage

// File: rtl/usb_pid_event_arb.sv
module usb_pid_event_arb #(
  parameter bit DEF_CTRL = 1'b1
) (
  input  logic host_mode_i,
  input  logic is_bulk_i,
  input  logic snak_en_i,
  input  logic ev_setup_i,
  input  logic ev_stall_hs_i,
  input  logic ev_oversize_i,
  input  logic ev_short_i,
  input  logic ev_trn_end_i,
  input  logic ev_seq_err_i,
  output logic force_stall_o,
  output logic force_nak_o
);
  logic stall_host, stall_func, nak_bulk, nak_setup;

  assign stall_host = host_mode_i & ev_stall_hs_i;
  assign stall_func = ~host_mode_i & ev_seq_err_i;
  assign nak_bulk   = is_bulk_i & snak_en_i & (ev_short_i | ev_trn_end_i);

  generate
    if (DEF_CTRL) begin : g_dcp
      assign nak_setup = ~host_mode_i & ev_setup_i;
    end else begin : g_no_dcp
      assign nak_setup = 1'b0;
    end
  endgenerate

  assign force_stall_o = ev_oversize_i | stall_host | stall_func;
  // STALL outranks NAK
  assign force_nak_o   = ~force_stall_o & (nak_bulk | nak_setup);
endmodule

// File: rtl/usb_pid_state.sv
module usb_pid_state
  import usb_pid_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       force_stall_i,
  input  logic       force_nak_i,
  input  logic       sw_wr_i,
  input  logic [1:0] sw_pid_i,
  output logic [1:0] pid_o
);
  logic [1:0] pid_q, pid_d;

  always_comb begin
    pid_d = pid_q;
    if (force_stall_i)    pid_d = PID_STALL;
    else if (force_nak_i) pid_d = PID_NAK;
    else if (sw_wr_i)     pid_d = sw_pid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pid_q <= PID_NAK;
    else         pid_q <= pid_d;
  end

  assign pid_o = pid_q;
endmodule

// File: rtl/usb_pipe_cfg_regs.sv
module usb_pipe_cfg_regs
  import usb_pid_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            locked_i,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [DATA_W-1:0]               wr_data_i,
  output logic                            done_o,
  output logic [DATA_W-4:0]               misc_o,
  output logic [NUM_CFG-1:0][DATA_W-1:0]  regs_o
);
  localparam int unsigned MISC_W = DATA_W - 3;

  logic              ctl_hit;
  logic              done_q;
  logic [MISC_W-1:0] misc_q;

  assign ctl_hit = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTL));

  // control-complete bit stays writable in any PID state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      misc_q <= '0;
    end else if (ctl_hit) begin
      done_q <= wr_data_i[CTL_DONE];
      if (!locked_i) misc_q <= wr_data_i[DATA_W-1:3];
    end
  end

  assign done_o = done_q;
  assign misc_o = misc_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CFG; gi++) begin : g_reg
      logic              hit;
      logic [DATA_W-1:0] q;
      assign hit = wr_en_i && !locked_i &&
                   (wr_addr_i == ADDR_W'(REG_CFG + gi));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wr_data_i;
      end
      assign regs_o[gi] = q;
    end
  endgenerate
endmodule

// File: rtl/usb_pid_resp.sv
module usb_pid_resp
  import usb_pid_pkg::*;
(
  input  logic       host_mode_i,
  input  logic [1:0] pid_i,
  output logic       token_en_o,
  output logic [1:0] hs_sel_o
);
  always_comb begin
    unique case (pid_i)
      PID_NAK: hs_sel_o = HS_NAK;
      PID_BUF: hs_sel_o = HS_ACK;
      default: hs_sel_o = HS_STALL;
    endcase
  end

  assign token_en_o = host_mode_i && (pid_i == PID_BUF);
endmodule

// File: rtl/usb_pipe_pid_ctrl.sv
module usb_pipe_pid_ctrl
  import usb_pid_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter bit          DEF_CTRL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ev_setup_i,
  input  logic              ev_stall_hs_i,
  input  logic              ev_oversize_i,
  input  logic              ev_short_i,
  input  logic              ev_trn_end_i,
  input  logic              ev_seq_err_i,
  output logic [1:0]        pid_o,
  output logic              token_en_o,
  output logic [1:0]        hs_sel_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] buf_cfg_o,
  output logic [DATA_W-1:0] maxp_o,
  output logic [DATA_W-1:0] period_o
);
  logic                           force_stall, force_nak, sw_pid_wr, locked;
  logic [1:0]                     pid;
  logic                           done;
  logic [DATA_W-4:0]              misc;
  logic [NUM_CFG-1:0][DATA_W-1:0] regs;

  assign sw_pid_wr = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTL));
  assign locked    = (pid == PID_BUF);

  usb_pid_event_arb #(.DEF_CTRL(DEF_CTRL)) i_arb (
    .host_mode_i   (host_mode_i),
    .is_bulk_i     (regs[0][CFG_BULK]),
    .snak_en_i     (regs[0][CFG_SNAK]),
    .ev_setup_i    (ev_setup_i),
    .ev_stall_hs_i (ev_stall_hs_i),
    .ev_oversize_i (ev_oversize_i),
    .ev_short_i    (ev_short_i),
    .ev_trn_end_i  (ev_trn_end_i),
    .ev_seq_err_i  (ev_seq_err_i),
    .force_stall_o (force_stall),
    .force_nak_o   (force_nak)
  );

  usb_pid_state i_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .force_stall_i (force_stall),
    .force_nak_i   (force_nak),
    .sw_wr_i       (sw_pid_wr),
    .sw_pid_i      (wr_data_i[1:0]),
    .pid_o         (pid)
  );

  usb_pipe_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .locked_i  (locked),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .done_o    (done),
    .misc_o    (misc),
    .regs_o    (regs)
  );

  usb_pid_resp i_resp (
    .host_mode_i (host_mode_i),
    .pid_i       (pid),
    .token_en_o  (token_en_o),
    .hs_sel_o    (hs_sel_o)
  );

  assign pid_o     = pid;
  assign ctl_o     = {misc, done, pid};
  assign cfg_o     = regs[0];
  assign buf_cfg_o = regs[1];
  assign maxp_o    = regs[2];
  assign period_o  = regs[3];
endmodule

// File: rtl/usb_pipe_pid_ctrl_chk.sv
module usb_pipe_pid_ctrl_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter bit          DEF_CTRL = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_mode_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              ev_setup_i,
  input logic              ev_stall_hs_i,
  input logic              ev_oversize_i,
  input logic              ev_short_i,
  input logic              ev_trn_end_i,
  input logic              ev_seq_err_i,
  input logic [1:0]        pid_o,
  input logic              token_en_o,
  input logic [1:0]        hs_sel_o,
  input logic [DATA_W-1:0] ctl_o,
  input logic [DATA_W-1:0] cfg_o,
  input logic [DATA_W-1:0] buf_cfg_o,
  input logic [DATA_W-1:0] maxp_o,
  input logic [DATA_W-1:0] period_o
);
  logic any_stall;
  assign any_stall = ev_oversize_i | (host_mode_i & ev_stall_hs_i) |
                     (~host_mode_i & ev_seq_err_i);

  // R3
  host_stall_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && ev_stall_hs_i) |=> pid_o[1]);

  // R4
  oversize_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_oversize_i |=> pid_o[1]);

  // R7
  seq_err_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && ev_seq_err_i) |=> pid_o[1]);

  // R5
  short_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[0] && cfg_o[1] && (ev_short_i || ev_trn_end_i) && !any_stall)
    |=> (pid_o == 2'b00));

  // R2
  no_hw_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pid_o != 2'b01) &&
     !(wr_en_i && (wr_addr_i == '0) && (wr_data_i[1:0] == 2'b01)))
    |=> (pid_o != 2'b01));

  // R9
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pid_o == 2'b01) && wr_en_i && (wr_addr_i != '0)) |=>
    ($stable(cfg_o) && $stable(buf_cfg_o) && $stable(maxp_o) && $stable(period_o)));

  // R10
  token_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_en_o |-> (host_mode_i && (pid_o == 2'b01)));

  // R11
  hs_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pid_o[1] |-> (hs_sel_o == 2'b10));
endmodule

bind usb_pipe_pid_ctrl usb_pipe_pid_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_CTRL(DEF_CTRL)
) i_chk (.*);

// File: tb/test_usb_pipe_pid_ctrl.sv
`timescale 1ns/1ps
module test_usb_pipe_pid_ctrl;
  localparam int DW = 16;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic ev_setup = 0, ev_sth = 0, ev_ovs = 0, ev_short = 0, ev_trn = 0, ev_seq = 0;
  logic [1:0] pid, hs;
  logic tok;
  logic [DW-1:0] ctl, cfg, bufc, maxp, peri;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // model state
  logic [1:0]    m_pid = 2'b00;
  logic          m_done = 1'b0;
  logic [DW-4:0] m_misc = '0;
  logic [DW-1:0] m_reg [4];

  always #5 clk = ~clk;

  usb_pipe_pid_ctrl #(.DATA_W(DW), .ADDR_W(AW), .DEF_CTRL(1'b1)) i_usb_pipe_pid_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ev_setup_i(ev_setup),
    .ev_stall_hs_i(ev_sth), .ev_oversize_i(ev_ovs), .ev_short_i(ev_short),
    .ev_trn_end_i(ev_trn), .ev_seq_err_i(ev_seq), .pid_o(pid),
    .token_en_o(tok), .hs_sel_o(hs), .ctl_o(ctl), .cfg_o(cfg),
    .buf_cfg_o(bufc), .maxp_o(maxp), .period_o(peri)
  );

  function automatic logic [1:0] exp_hs(input logic [1:0] p);
    return (p == 2'b00) ? 2'b00 : (p == 2'b01) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step();
    logic stall, nak, lock;
    stall = ev_ovs | (host & ev_sth) | (!host & ev_seq);
    nak   = (m_reg[0][0] & m_reg[0][1] & (ev_short | ev_trn)) | (!host & ev_setup);
    lock  = (m_pid == 2'b01);
    if (wr_en) begin
      if (wr_addr == 0) begin
        m_done = wr_data[2];
        if (!lock) m_misc = wr_data[DW-1:3];
      end else if (wr_addr <= 4 && !lock) m_reg[wr_addr-1] = wr_data;
    end
    if (stall)      m_pid = 2'b10;
    else if (nak)   m_pid = 2'b00;
    else if (wr_en && wr_addr == 0) m_pid = wr_data[1:0];
  endtask

  // inputs set beforehand at negedge; advance one clock and clear strobes
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; ev_setup = 0; ev_sth = 0; ev_ovs = 0; ev_short = 0; ev_trn = 0; ev_seq = 0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; tick();
  endtask

  task automatic cmp_model();
    chk("R8 pid", 32'(pid), 32'(m_pid));
    chk("R11 hs", 32'(hs), 32'(exp_hs(m_pid)));
    chk("R10 tok", 32'(tok), 32'(host && m_pid == 2'b01));
    chk("R9 ctl", 32'(ctl), 32'({m_misc, m_done, m_pid}));
    chk("R9 cfg", 32'(cfg), 32'(m_reg[0]));
    chk("R9 buf", 32'(bufc), 32'(m_reg[1]));
    chk("R9 maxp", 32'(maxp), 32'(m_reg[2]));
    chk("R9 peri", 32'(peri), 32'(m_reg[3]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 pid", 32'(pid), 0); chk("R1 tok", 32'(tok), 0);
    chk("R1 hs", 32'(hs), 0);   chk("R1 cfg", 32'(cfg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl", 32'(ctl), 0);

    // R2 / R10 / R11: software BUF in host mode
    host = 1; wr(0, 16'h0001);
    chk("R2 buf", 32'(pid), 1); chk("R10 tok", 32'(tok), 1); chk("R11 ack", 32'(hs), 1);
    // R3: STALL handshake in host mode
    ev_sth = 1; tick();
    chk("R3 stall", 32'(pid), 2); chk("R10 tok off", 32'(tok), 0); chk("R11 stall", 32'(hs), 2);
    // R3: ignored in function mode
    host = 0; wr(0, 16'h0001); ev_sth = 1; tick();
    chk("R3 func ignore", 32'(pid), 1); chk("R10 func tok", 32'(tok), 0);
    // R4: oversize in function mode
    ev_ovs = 1; tick(); chk("R4 oversize", 32'(pid), 2);
    // R5: bulk without short-NAK -> short ignored
    wr(0, 16'h0000); wr(1, 16'h0001); wr(0, 16'h0001);
    ev_short = 1; tick(); chk("R5 no snak", 32'(pid), 1);
    // R5: bulk + short-NAK
    wr(0, 16'h0000); wr(1, 16'h0003); wr(0, 16'h0001);
    ev_short = 1; tick(); chk("R5 short", 32'(pid), 0);
    host = 1; wr(0, 16'h0001); ev_trn = 1; tick(); chk("R5 trn end", 32'(pid), 0);
    // R6: SETUP ignored in host, forces NAK in function
    wr(0, 16'h0001); ev_setup = 1; tick(); chk("R6 host ignore", 32'(pid), 1);
    host = 0; ev_setup = 1; tick(); chk("R6 setup", 32'(pid), 0);
    // R7: sequence error
    wr(0, 16'h0001); host = 1; ev_seq = 1; tick(); chk("R7 host ignore", 32'(pid), 1);
    host = 0; ev_seq = 1; tick(); chk("R7 seq err", 32'(pid), 2);
    // R8: STALL beats NAK, events beat a PID write
    wr(0, 16'h0001); ev_short = 1; ev_ovs = 1; tick(); chk("R8 prio", 32'(pid), 2);
    wr_en = 1; wr_addr = 0; wr_data = 16'h0001; ev_short = 1; tick();
    chk("R8 hw over sw", 32'(pid), 0);
    // R9: lock while BUF
    wr(0, 16'h0001);
    wr(2, 16'hBEEF); chk("R9 buf locked", 32'(bufc), 0);
    wr(1, 16'h0000); chk("R9 cfg locked", 32'(cfg), 3);
    wr(0, 16'hFFFD); chk("R9 ctl partial", 32'(ctl), 32'h0005);
    wr(5, 16'h1234); cmp_model();
    wr(0, 16'h0000); wr(3, 16'h0040); chk("R9 unlocked", 32'(maxp), 32'h0040);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      host     = ($urandom % 4) == 0 ? ~host : host;
      ev_setup = ($urandom % 10) == 0;
      ev_sth   = ($urandom % 12) == 0;
      ev_ovs   = ($urandom % 16) == 0;
      ev_short = ($urandom % 8) == 0;
      ev_trn   = ($urandom % 10) == 0;
      ev_seq   = ($urandom % 14) == 0;
      wr_en    = ($urandom % 3) == 0;
      wr_addr  = AW'($urandom % 7);
      wr_data  = DW'($urandom);
      if (wr_addr == 0 && ($urandom % 2)) wr_data[1:0] = 2'b01;
      tick();
      cmp_model();
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule